// File: doc/BRIEF.md
# Asynchronous Static RAM Strobe Sequencer

This block sits between a synchronous host and an external asynchronous static RAM of 1M words by 4 bits with one shared bidirectional data bus. The host asks for one word at a time through a valid/ready handshake. The block then generates the memory's active-low select, write-enable and output-enable strobes, holds the address steady, and switches its own data drivers on and off. All timing comes from counting clock cycles, and parameters set every count.

A read keeps select and output-enable low for a set number of cycles. The word on the bus is captured in the last of those cycles and returned to the host with a one-cycle valid pulse. The strobes then stay high for a turnaround gap, so the memory can release the bus before anyone else drives it. A write first presents the address and data with all strobes high (setup). Select and write-enable then fall together for the pulse, and both rise together before a recovery period in which the address and data are still held. Output-enable never goes low during a write, and the data drivers are only ever on while output-enable is high.

Top module: `sram_ctl`

## Requirements
- R1: After a synchronous reset, including one that arrives in the middle of an operation, req_ready is 1, rd_valid is 0, mem_cs_n, mem_we_n and mem_oe_n are all 1, and mem_dq_oe is 0.
- R2: A read (req_write=0) holds mem_cs_n=0, mem_oe_n=0 and mem_we_n=1 for exactly RD_CYC cycles, with mem_addr equal to the accepted address.
- R3: Read data is sampled from mem_dq_in during the last of the RD_CYC access cycles. In the following cycle it appears on rd_data, with rd_valid high for exactly one cycle.
- R4: A write (req_write=1) holds mem_cs_n=0 and mem_we_n=0 together for exactly WR_CYC cycles, and mem_oe_n stays 1 for the whole write.
- R5: mem_addr stays fixed at the accepted address from acceptance until req_ready returns. During a write it is presented with all strobes high for SETUP_CYC cycles before the pulse and for REC_CYC cycles after it.
- R6: Write-enable falls no later than select. The memory is never selected with both mem_we_n and mem_oe_n high.
- R7: mem_dq_oe is 1 only while mem_oe_n is 1, and only after mem_oe_n has been high for at least TURN_CYC cycles. During a write it covers the setup, pulse and recovery cycles and no others.
- R8: req_ready is 1 only in the idle state with all strobes high. A request is taken only on a cycle where req_valid and req_ready are both 1. Requests presented while busy are ignored, and consecutive operations are separated by at least one idle cycle.
- R9: After a read, mem_cs_n and mem_oe_n stay high with the drivers off for exactly TURN_CYC cycles before req_ready returns.
- R10: Whenever mem_dq_oe is 1, mem_dq_out equals the write data accepted with the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host presents a request |
| req_ready | output | 1 | Block is idle and takes a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rd_data | output | DATA_W | Last read word |
| rd_valid | output | 1 | One-cycle pulse when rd_data is new |
| mem_cs_n | output | 1 | Memory select, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq_out | output | DATA_W | Data to drive onto the shared bus |
| mem_dq_oe | output | 1 | Enables the bus drivers for mem_dq_out |
| mem_dq_in | input | DATA_W | Data sampled from the shared bus |

## Verification
Some properties are checked on every cycle: the strobe pairing rule, bus contention, the turnaround count before the drivers switch on, the width of the write pulse, address stability while busy, and the single-cycle read-valid pulse. Other behaviour can only be shown by the bench scenarios. These cover correct data moving through a memory model that returns valid data only on the final access cycle, the exact setup, recovery and turnaround counts under non-default parameters, requests that are ignored while the block is busy, and a reset that arrives during a write pulse.

// File: rtl/sram_ctl_pkg.sv
// Package: shared sequencer state encoding for the static RAM controller.
package sram_ctl_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACC,
        ST_RD_TURN,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_REC
    } seq_state_t;
endpackage

// File: rtl/sram_ctl_timer.sv
// Down-counter that times each sequencer phase.
// Assumes: load_val is the phase length minus one; done is high when zero is reached.
module sram_ctl_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    // Reload on phase entry, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/sram_ctl_seq.sv
// Phase sequencer: walks the read and write phases and decodes the strobes from the state.
// Assumes: every cycle-count parameter is at least 1, and timer_done reflects the phase just loaded.
module sram_ctl_seq
    import sram_ctl_pkg::*;
#(
    parameter int RD_CYC    = 2,
    parameter int WR_CYC    = 2,
    parameter int SETUP_CYC = 1,
    parameter int REC_CYC   = 1,
    parameter int TURN_CYC  = 1,
    parameter int CNT_W     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             timer_done,
    output logic             timer_load,
    output logic [CNT_W-1:0] timer_val,
    output logic             accept,
    output logic             capture,
    output logic             ready,
    output logic             cs_n,
    output logic             we_n,
    output logic             oe_n,
    output logic             dq_oe
);
    seq_state_t state_q, state_d;

    // Next-state and phase-length selection.
    always_comb begin
        state_d    = state_q;
        timer_load = 1'b0;
        timer_val  = '0;
        accept     = 1'b0;
        capture    = 1'b0;
        unique case (state_q)
            ST_IDLE: if (req_valid) begin
                accept     = 1'b1;
                timer_load = 1'b1;
                if (req_write) begin
                    state_d   = ST_WR_SETUP;
                    timer_val = CNT_W'(SETUP_CYC - 1);
                end else begin
                    state_d   = ST_RD_ACC;
                    timer_val = CNT_W'(RD_CYC - 1);
                end
            end
            ST_RD_ACC: if (timer_done) begin
                capture    = 1'b1;
                timer_load = 1'b1;
                timer_val  = CNT_W'(TURN_CYC - 1);
                state_d    = ST_RD_TURN;
            end
            ST_RD_TURN: if (timer_done) state_d = ST_IDLE;
            ST_WR_SETUP: if (timer_done) begin
                timer_load = 1'b1;
                timer_val  = CNT_W'(WR_CYC - 1);
                state_d    = ST_WR_PULSE;
            end
            ST_WR_PULSE: if (timer_done) begin
                timer_load = 1'b1;
                timer_val  = CNT_W'(REC_CYC - 1);
                state_d    = ST_WR_REC;
            end
            ST_WR_REC: if (timer_done) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Strobe decode from the current phase.
    always_comb begin
        ready = (state_q == ST_IDLE);
        cs_n  = !(state_q == ST_RD_ACC || state_q == ST_WR_PULSE);
        we_n  = !(state_q == ST_WR_PULSE);
        oe_n  = !(state_q == ST_RD_ACC);
        dq_oe = (state_q == ST_WR_SETUP || state_q == ST_WR_PULSE ||
                 state_q == ST_WR_REC);
    end

    // Checker state: cycles since output-enable rose, and length of the current write pulse.
    logic [15:0] oe_free_q;
    logic [15:0] pulse_len_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_free_q   <= 16'(TURN_CYC);
            pulse_len_q <= '0;
        end else begin
            if (!oe_n)                          oe_free_q <= '0;
            else if (oe_free_q < 16'(TURN_CYC)) oe_free_q <= oe_free_q + 1'b1;
            if (!cs_n && !we_n)                 pulse_len_q <= pulse_len_q + 1'b1;
            else                                pulse_len_q <= '0;
        end
    end

    assert_strobe_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> (we_n != oe_n));
    assert_no_contention_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> oe_n);
    assert_turnaround_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (oe_free_q >= 16'(TURN_CYC)));
    assert_pulse_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_len_q != '0 && we_n) |-> (pulse_len_q == 16'(WR_CYC)));
    assert_ready_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (cs_n && we_n && oe_n && !dq_oe));
endmodule

// File: rtl/sram_ctl_dpath.sv
// Datapath: holds the accepted address and write data, captures read words and pulses valid.
// Assumes: accept occurs only in idle, and capture only on the last access cycle.
module sram_ctl_dpath #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] dq_in,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    // Latch the request on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr  <= '0;
            wdata <= '0;
        end else if (accept) begin
            addr  <= req_addr;
            wdata <= req_wdata;
        end
    end

    // Capture the bus word and raise valid for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= capture;
            if (capture) rdata <= dq_in;
        end
    end

    assert_valid_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |=> !rvalid);
endmodule

// File: rtl/sram_ctl.sv
// Top: asynchronous static RAM controller. Connects the sequencer, the phase timer and the datapath.
// Assumes: every cycle count is at least 1; mem_dq_in is the bus value seen by the pins.
module sram_ctl #(
    parameter int ADDR_W    = 20,
    parameter int DATA_W    = 4,
    parameter int RD_CYC    = 2,
    parameter int WR_CYC    = 2,
    parameter int SETUP_CYC = 1,
    parameter int REC_CYC   = 1,
    parameter int TURN_CYC  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int MAX_A   = (RD_CYC > WR_CYC) ? RD_CYC : WR_CYC;
    localparam int MAX_B   = (SETUP_CYC > REC_CYC) ? SETUP_CYC : REC_CYC;
    localparam int MAX_AB  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAX_CYC = (MAX_AB > TURN_CYC) ? MAX_AB : TURN_CYC;
    localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

    if (RD_CYC < 1 || WR_CYC < 1 || SETUP_CYC < 1 || REC_CYC < 1 || TURN_CYC < 1) begin : g_bad_cfg
        $error("sram_ctl: every cycle count must be at least 1");
    end

    logic             timer_load, timer_done, accept, capture;
    logic [CNT_W-1:0] timer_val;

    sram_ctl_seq #(
        .RD_CYC(RD_CYC), .WR_CYC(WR_CYC), .SETUP_CYC(SETUP_CYC),
        .REC_CYC(REC_CYC), .TURN_CYC(TURN_CYC), .CNT_W(CNT_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .timer_done(timer_done), .timer_load(timer_load), .timer_val(timer_val),
        .accept(accept), .capture(capture), .ready(req_ready),
        .cs_n(mem_cs_n), .we_n(mem_we_n), .oe_n(mem_oe_n), .dq_oe(mem_dq_oe)
    );

    sram_ctl_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(timer_load), .load_val(timer_val),
        .done(timer_done)
    );

    sram_ctl_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
        .clk(clk), .rst_n(rst_n), .accept(accept), .capture(capture),
        .req_addr(req_addr), .req_wdata(req_wdata), .dq_in(mem_dq_in),
        .addr(mem_addr), .wdata(mem_dq_out), .rdata(rd_data), .rvalid(rd_valid)
    );

    assert_addr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> $stable(mem_addr));
    assert_take_only_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && !req_valid) |=> req_ready);
endmodule

// File: tb/tb_sram_ctl.sv
// Bench: table of write/read vectors against a memory model, then directed corner cases.
module tb_sram_ctl;
    localparam int RD = 3, WR = 2, SU = 2, RC = 1, TN = 2;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_ready, rd_valid;
    logic [19:0] req_addr = '0, mem_addr;
    logic [3:0]  req_wdata = '0, rd_data, mem_dq_out, mem_dq_in = '0;
    logic        mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;

    int checks = 0, errors = 0;

    always #2.5 clk = ~clk;

    sram_ctl #(.RD_CYC(RD), .WR_CYC(WR), .SETUP_CYC(SU), .REC_CYC(RC), .TURN_CYC(TN)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_data(rd_data), .rd_valid(rd_valid), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    // Memory model: stores on write overlap, returns the true word only on the RD-th read cycle.
    logic [3:0] mem [int unsigned];
    int rd_run = 0;
    always @(posedge clk)
        if (!mem_cs_n && !mem_we_n && mem_dq_oe) mem[int'(mem_addr)] = mem_dq_out;
    always @(negedge clk) begin
        logic [3:0] w;
        if (!mem_cs_n && !mem_oe_n && mem_we_n) begin
            rd_run = rd_run + 1;
            w = mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 4'h0;
            mem_dq_in = (rd_run == RD) ? w : ~w;
        end else begin
            rd_run = 0;
            mem_dq_in = 4'h0;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Runs one operation and records what the strobes did until ready returns.
    task automatic run_op(input bit wr, input logic [19:0] a, input logic [3:0] d, input bit hold,
                          output int n_rd, output int n_wr, output int n_drv, output int n_turn,
                          output int n_val, output int n_bad, output logic [3:0] rdat);
        n_rd = 0; n_wr = 0; n_drv = 0; n_turn = 0; n_val = 0; n_bad = 0; rdat = 4'h0;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        if (hold) begin
            req_write = 1'b1; req_addr = 20'hFFFFF; req_wdata = 4'hF;
        end else req_valid = 1'b0;
        while (!req_ready) begin
            if (!mem_cs_n && !mem_oe_n && mem_we_n) n_rd++;
            if (!mem_cs_n && !mem_we_n) n_wr++;
            if (mem_dq_oe && mem_cs_n) n_drv++;
            if (!wr && mem_cs_n && mem_oe_n && !mem_dq_oe) n_turn++;
            if (rd_valid) begin n_val++; rdat = rd_data; end
            if (mem_addr != a) n_bad++;
            if (wr && !mem_oe_n) n_bad++;
            if (mem_dq_oe && mem_dq_out != d) n_bad++;
            if (!mem_cs_n && mem_we_n && mem_oe_n) n_bad++;
            if (mem_dq_oe && !mem_oe_n) n_bad++;
            @(negedge clk);
        end
        req_valid = 1'b0;
    endtask

    // {write, address, data, expected read}
    localparam logic [28:0] VEC [10] = '{
        {1'b1, 20'h00000, 4'h5, 4'h0},
        {1'b1, 20'hFFFFF, 4'hA, 4'h0},
        {1'b1, 20'h12345, 4'h3, 4'h0},
        {1'b1, 20'h80001, 4'hC, 4'h0},
        {1'b0, 20'h00000, 4'h0, 4'h5},
        {1'b0, 20'hFFFFF, 4'h0, 4'hA},
        {1'b0, 20'h12345, 4'h0, 4'h3},
        {1'b0, 20'h80001, 4'h0, 4'hC},
        {1'b1, 20'h12345, 4'h9, 4'h0},
        {1'b0, 20'h12345, 4'h0, 4'h9}
    };

    task automatic check_op(input bit wr, input logic [3:0] expd, input int n_rd, input int n_wr,
                            input int n_drv, input int n_turn, input int n_val, input int n_bad,
                            input logic [3:0] rdat);
        check(n_bad == 0, "R5/R6/R10 address, strobe pair or drive data", n_bad, 0);
        check(mem_cs_n && mem_we_n && mem_oe_n, "R8 idle cycle between operations",
              {mem_cs_n, mem_we_n, mem_oe_n}, 7);
        if (wr) begin
            check(n_wr == WR, "R4 write pulse width", n_wr, WR);
            check(n_drv == SU + RC, "R5/R7 setup plus recovery driven cycles", n_drv, SU + RC);
            check(n_val == 0, "R3 no valid on write", n_val, 0);
        end else begin
            check(n_rd == RD, "R2 read access width", n_rd, RD);
            check(n_turn == TN, "R9 turnaround gap", n_turn, TN);
            check(n_val == 1, "R3 single valid pulse", n_val, 1);
            check(rdat == expd, "R3 read data", rdat, expd);
        end
    endtask

    initial begin
        int n_rd, n_wr, n_drv, n_turn, n_val, n_bad;
        logic [3:0] rdat;
        repeat (3) @(negedge clk);
        check(req_ready && !rd_valid && mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe,
              "R1 reset state", {req_ready, rd_valid, mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}, 6'b101110);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < 10; i++) begin
            run_op(VEC[i][28], VEC[i][27:8], VEC[i][7:4], 1'b0,
                   n_rd, n_wr, n_drv, n_turn, n_val, n_bad, rdat);
            check_op(VEC[i][28], VEC[i][3:0], n_rd, n_wr, n_drv, n_turn, n_val, n_bad, rdat);
        end

        // R8: a request held while busy must not be taken; then read back the untouched word.
        run_op(1'b0, 20'h00000, 4'h0, 1'b1, n_rd, n_wr, n_drv, n_turn, n_val, n_bad, rdat);
        check_op(1'b0, 4'h5, n_rd, n_wr, n_drv, n_turn, n_val, n_bad, rdat);
        @(negedge clk);
        check(req_ready && mem_cs_n, "R8 held request ignored, still idle", req_ready, 1);
        run_op(1'b0, 20'hFFFFF, 4'h0, 1'b0, n_rd, n_wr, n_drv, n_turn, n_val, n_bad, rdat);
        check(rdat == 4'hA, "R8 busy request did not write", rdat, 4'hA);

        // R7: a write right after a read keeps the drivers off while output-enable is low.
        run_op(1'b1, 20'h0F0F0, 4'h6, 1'b0, n_rd, n_wr, n_drv, n_turn, n_val, n_bad, rdat);
        check_op(1'b1, 4'h0, n_rd, n_wr, n_drv, n_turn, n_val, n_bad, rdat);

        // R1: reset during a write pulse returns every strobe to idle.
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 20'h00ABC; req_wdata = 4'h7;
        @(negedge clk);
        req_valid = 1'b0;
        while (mem_we_n) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(req_ready && !rd_valid && mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe,
              "R1 reset mid-write", {req_ready, mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}, 5'b11110);
        rst_n = 1'b1;
        @(negedge clk);
        run_op(1'b0, 20'h0F0F0, 4'h0, 1'b0, n_rd, n_wr, n_drv, n_turn, n_val, n_bad, rdat);
        check_op(1'b0, 4'h6, n_rd, n_wr, n_drv, n_turn, n_val, n_bad, rdat);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule